// File: doc/BRIEF.md
# External Bus Lending Controller

This block lets an external DMA master borrow a CPU's external memory bus. It watches an active-low hold request pin. Once the request is seen and the CPU's current bus cycle has reached its final state, it floats the address, data, strobe and chip-enable drivers. One clock later it drives an active-low grant pin. While the bus is lent, the CPU core is stalled, so it starts no new bus cycle, and internal memory is fenced off from the outside. The lent period runs as pairs of idle states. When the request is withdrawn, the controller finishes the current pair, raises the grant, and re-enables its drivers one clock after that.

The request and grant pins are shared with one general-purpose input port bit and one output port bit. A software-written mode bit chooses between them. In port mode, which is the reset state and is meant for single-chip systems, the request pin is only a readable input and the grant pin shows a software-written port bit. The request pin always passes through a synchronizer before any logic uses it.

Top module: `xbus_release`

## Requirements
- R1: After reset the block is in port mode. The grant pin is high (the port bit resets to 1), the bus drivers are enabled, stall is low, internal memory is not fenced and the idle phase is 0.
- R2: The request pin reaches `port_in` (and the arbiter) through a two-flop synchronizer. A pin change shows up after the second rising edge following it.
- R3: The mode bit (1 = bus function) and the port bit load on the rising edge after a cycle with `cfg_we` high, and hold at all other times. In port mode a low request pin causes no stall and no float, and the grant pin drives the port bit.
- R4: In bus mode with the CPU idle, a request driven low just after edge k disables the drivers at edge k+3. If a CPU bus cycle is in progress, the drivers stay enabled until the edge that ends the cycle's final state (`cpu_cyc_last` high).
- R5: Stall is high from the cycle in which the synchronized request is seen until the edge at which the drivers are re-enabled.
- R6: The grant pin goes low exactly one edge after the drivers are disabled, and it is never low while the drivers are enabled.
- R7: While the bus is lent, `idle_phase` alternates 0,1,0,1… starting at 0. The lent period ends only after a phase-1 cycle, so it lasts an even number of cycles and at least 2.
- R8: After the request pin returns high, the grant rises at the first edge that is at least 3 edges later and ends an idle pair. The drivers are re-enabled, and stall drops, one edge after that.
- R9: `imem_block` is high on exactly the cycles in which the drivers are disabled.
- R10: `dat_oe` follows `cpu_dat_drive` only while the CPU owns the bus. It is low while the bus is lent.
- R11: If the request is withdrawn before the grant goes low, the controller still completes one idle pair and returns the bus. The bench flags this case as a protocol violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bus_mode_d | input | 1 | Mode bit to write: 1 = bus request/grant, 0 = port |
| cfg_port_d | input | 1 | Output port bit to write |
| hold_req_n | input | 1 | Shared request / input-port pin, active low |
| port_in | output | 1 | Synchronized value of the request pin |
| grant_n | output | 1 | Shared grant / output-port pin, active low |
| cpu_cyc_active | input | 1 | CPU bus cycle in progress |
| cpu_cyc_last | input | 1 | Final state of the current CPU bus cycle |
| cpu_dat_drive | input | 1 | CPU wants to drive the data bus |
| cpu_stall | output | 1 | Holds the CPU core from starting bus cycles |
| adr_oe | output | 1 | Address driver enable |
| ctl_oe | output | 1 | Strobe and chip-enable driver enable |
| dat_oe | output | 1 | Data driver enable |
| imem_block | output | 1 | Fences internal memory while the bus is lent |
| idle_phase | output | 1 | Idle-pair phase during the lent period |

## Verification
Every cycle, the assertions check that the float happens only at a cycle boundary, that the grant falls only after the drivers are off, that the drivers return only one clock after the grant rises, that a lent period ends on a phase-1 cycle, and that configuration holds without a write. Only the bench's scenarios can show the exact handover latencies: idle and busy CPU, the parity of the release edge for different hold times, synchronizer delay, port-mode pin behaviour and the flagged early withdrawal.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  typedef enum logic [1:0] {
    ST_OWN     = 2'd0,
    ST_FLOAT   = 2'd1,
    ST_LENT    = 2'd2,
    ST_RESTORE = 2'd3
  } xbr_state_e;
endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xbr_cfg.sv
module xbr_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_bus_mode_d,
  input  logic cfg_port_d,
  input  logic ack_low,
  output logic bus_mode,
  output logic grant_n
);
  logic mode_q, mode_d;
  logic port_q, port_d;

  always_comb begin
    mode_d = mode_q;
    port_d = port_q;
    if (cfg_we) begin
      mode_d = cfg_bus_mode_d;
      port_d = cfg_port_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      port_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      port_q <= port_d;
    end
  end

  assign bus_mode = mode_q;
  assign grant_n  = mode_q ? ~ack_low : port_q;

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($stable(mode_q) && $stable(port_q)));
endmodule

// File: rtl/xbr_arb.sv
module xbr_arb
  import xbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_act,
  input  logic cyc_active,
  input  logic cyc_last,
  output logic drv_en,
  output logic ack_low,
  output logic stall,
  output logic fence,
  output logic phase
);
  xbr_state_e st_q, st_d;
  logic       ph_q, ph_d;
  logic       boundary;

  assign boundary = !cyc_active || cyc_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OWN:     if (req_act && boundary) st_d = ST_FLOAT;
      ST_FLOAT:   st_d = ST_LENT;
      ST_LENT:    if (!req_act && ph_q) st_d = ST_RESTORE;
      ST_RESTORE: st_d = ST_OWN;
      default:    st_d = ST_OWN;
    endcase
    ph_d = (st_q == ST_LENT) ? ~ph_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OWN;
      ph_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign drv_en  = (st_q == ST_OWN);
  assign ack_low = (st_q == ST_LENT);
  assign fence   = (st_q != ST_OWN);
  assign stall   = (st_q != ST_OWN) || req_act;
  assign phase   = ph_q;

  // R4
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> $past(!cyc_active || cyc_last));
  // R6
  ack_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_low |-> !$past(drv_en));
  // R7
  pair_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_low) |-> $past(ph_q));
  // R8
  restore_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> !$past(ack_low));
  // R5
  stall_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(stall));
endmodule

// File: rtl/xbus_release.sv
module xbus_release #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_bus_mode_d,
  input  logic cfg_port_d,
  input  logic hold_req_n,
  output logic port_in,
  output logic grant_n,
  input  logic cpu_cyc_active,
  input  logic cpu_cyc_last,
  input  logic cpu_dat_drive,
  output logic cpu_stall,
  output logic adr_oe,
  output logic ctl_oe,
  output logic dat_oe,
  output logic imem_block,
  output logic idle_phase
);
  logic srst_n;
  logic req_s;
  logic bus_mode;
  logic ack_low;
  logic drv_en;

  xbr_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(srst_n)
  );

  xbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req (
    .clk(clk), .arst_n(srst_n), .d(hold_req_n), .q(req_s)
  );

  xbr_cfg u_cfg (
    .clk(clk), .rst_n(srst_n), .cfg_we(cfg_we),
    .cfg_bus_mode_d(cfg_bus_mode_d), .cfg_port_d(cfg_port_d),
    .ack_low(ack_low), .bus_mode(bus_mode), .grant_n(grant_n)
  );

  xbr_arb u_arb (
    .clk(clk), .rst_n(srst_n), .req_act(bus_mode && !req_s),
    .cyc_active(cpu_cyc_active), .cyc_last(cpu_cyc_last),
    .drv_en(drv_en), .ack_low(ack_low), .stall(cpu_stall),
    .fence(imem_block), .phase(idle_phase)
  );

  assign port_in = req_s;
  assign adr_oe  = drv_en;
  assign ctl_oe  = drv_en;
  assign dat_oe  = drv_en && cpu_dat_drive;

  // R6
  grant_pin_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_mode && !grant_n) |-> !adr_oe);
endmodule

// File: tb/xbus_release_test.sv
`timescale 1ns/1ps
module xbus_release_test;
  localparam int EV_OE_FALL = 0, EV_ACK_FALL = 1, EV_ACK_RISE = 2, EV_OE_RISE = 3;

  logic clk, rst_n, cfg_we, cfg_bus_mode_d, cfg_port_d, hold_req_n;
  logic port_in, grant_n, cpu_cyc_active, cpu_cyc_last, cpu_dat_drive;
  logic cpu_stall, adr_oe, ctl_oe, dat_oe, imem_block, idle_phase;

  xbus_release uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bus_mode_d(cfg_bus_mode_d),
    .cfg_port_d(cfg_port_d), .hold_req_n(hold_req_n), .port_in(port_in),
    .grant_n(grant_n), .cpu_cyc_active(cpu_cyc_active), .cpu_cyc_last(cpu_cyc_last),
    .cpu_dat_drive(cpu_dat_drive), .cpu_stall(cpu_stall), .adr_oe(adr_oe),
    .ctl_oe(ctl_oe), .dat_oe(dat_oe), .imem_block(imem_block), .idle_phase(idle_phase)
  );

  typedef struct { int kind; int cyc; string tag; } ev_t;
  ev_t sb_q[$];

  int cyc = 0, checks = 0, errors = 0, viol = 0;
  bit mon_en = 0, bus_on = 0, armed = 0, done = 0;
  logic prev_oe = 1'b1, prev_grant = 1'b1;

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, got, exp);
    end
  endtask

  task automatic push(input int kind, input int at, input string tag);
    ev_t e;
    e.kind = kind; e.cyc = at; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic sb_match(input int kind);
    ev_t e;
    checks++;
    if (sb_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard unexpected event kind=%0d cyc=%0d actual=%0d expected=none", kind, cyc, kind);
    end else begin
      e = sb_q.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        errors++;
        $display("FAIL %s event actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                 e.tag, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  // Monitor: records pin edges and pops the expected ones.
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (prev_oe && !adr_oe) sb_match(EV_OE_FALL);
      if (!prev_oe && adr_oe) sb_match(EV_OE_RISE);
      if (prev_grant && !grant_n) sb_match(EV_ACK_FALL);
      if (!prev_grant && grant_n) sb_match(EV_ACK_RISE);
      if (bus_on && !hold_req_n && grant_n && adr_oe) armed = 1;
      if (!grant_n) armed = 0;
      if (armed && hold_req_n) begin
        viol++; armed = 0;
        $display("NOTE R11 protocol violation: request withdrawn before grant at cyc %0d", cyc);
      end
    end
    prev_oe = adr_oe;
    prev_grant = grant_n;
  end

  task automatic cfg_write(input logic mode, input logic port);
    @(negedge clk);
    cfg_we = 1; cfg_bus_mode_d = mode; cfg_port_d = port;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Driver: one lend/return handshake; expected events go into the scoreboard.
  task automatic grant_seq(input int busy, input int hold, input logic dat);
    int k, fall, r, m, e;
    @(negedge clk);
    k = cyc; hold_req_n = 0;
    if (busy > 0) begin cpu_cyc_active = 1; cpu_dat_drive = dat; end
    fall = (busy > 3) ? k + busy : k + 3;
    r = fall + 1;
    push(EV_OE_FALL, fall, "R4");
    push(EV_ACK_FALL, r, "R6");
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (busy > 0 && cyc == fall - 1) cpu_cyc_last = 1;
      if (busy > 0 && cyc == fall) begin cpu_cyc_active = 0; cpu_cyc_last = 0; end
      if (busy > 0 && cyc == k + 3) begin
        check("R5 stall while cycle finishes", cpu_stall, 1);
        check("R4 drivers kept during cycle", adr_oe, 1);
        check("R10 data driven while owning", dat_oe, dat);
      end
      if (cyc == r) check("R7 first idle phase", idle_phase, 0);
      if (cyc == r + 1) begin
        check("R7 second idle phase", idle_phase, 1);
        check("R9 fence while lent", imem_block, 1);
        check("R10 data off while lent", dat_oe, 0);
        check("R4 strobes floated", ctl_oe, 0);
        check("R5 stall while lent", cpu_stall, 1);
      end
    end
    m = cyc; hold_req_n = 1;
    e = m + 3;
    if (((e - r) % 2) != 0) e++;
    push(EV_ACK_RISE, e, "R8");
    push(EV_OE_RISE, e + 1, "R8");
    while (cyc < e + 1) begin
      @(negedge clk);
      if (cyc == e) begin
        check("R8 stall held in restore", cpu_stall, 1);
        check("R9 fence in restore", imem_block, 1);
      end
      if (cyc == e + 1) begin
        check("R8 stall released", cpu_stall, 0);
        check("R9 fence released", imem_block, 0);
        check("R8 strobes restored", ctl_oe, 1);
      end
    end
    cpu_dat_drive = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int k;
    rst_n = 0; cfg_we = 0; cfg_bus_mode_d = 0; cfg_port_d = 1; hold_req_n = 1;
    cpu_cyc_active = 0; cpu_cyc_last = 0; cpu_dat_drive = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 grant pin", grant_n, 1);
    check("R1 drivers", adr_oe, 1);
    check("R1 stall", cpu_stall, 0);
    check("R1 fence", imem_block, 0);
    check("R1 phase", idle_phase, 0);
    check("R1 port input", port_in, 1);

    // R2 synchronizer latency, R3 port mode ignores the request
    @(negedge clk);
    k = cyc; hold_req_n = 0;
    @(negedge clk);
    check("R2 port_in one edge later", port_in, 1);
    @(negedge clk);
    check("R2 port_in two edges later", port_in, 0);
    repeat (3) @(negedge clk);
    check("R3 no stall in port mode", cpu_stall, 0);
    check("R3 drivers kept in port mode", adr_oe, 1);
    check("R3 grant pin shows port bit", grant_n, 1);
    cpu_dat_drive = 1;
    #1 check("R10 data follows cpu", dat_oe, 1);
    cpu_dat_drive = 0;
    cfg_write(1'b0, 1'b0);
    check("R3 port bit written", grant_n, 0);
    cfg_we = 0; cfg_bus_mode_d = 1; cfg_port_d = 1;
    repeat (2) @(negedge clk);
    check("R3 no change without write", grant_n, 0);
    hold_req_n = 1;
    repeat (3) @(negedge clk);
    check("R2 port_in back high", port_in, 1);

    // switch to bus function with the request idle
    cfg_write(1'b1, 1'b0);
    check("R3 grant idle high in bus mode", grant_n, 1);
    bus_on = 1;
    repeat (2) @(negedge clk);
    mon_en = 1;

    grant_seq(0, 8, 1'b0);   // idle CPU, even hold
    grant_seq(6, 9, 1'b1);   // busy CPU cycle with data
    grant_seq(0, 7, 1'b0);   // other release parity
    grant_seq(0, 2, 1'b0);   // R11 early withdrawal
    repeat (4) @(negedge clk);

    check("R11 violation flagged once", viol, 1);
    check("R8 scoreboard drained", sb_q.size(), 0);
    check("R8 bus back with CPU", adr_oe, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule